// File: doc/BRIEF.md
# Two-Agent Byte Mailbox with Ownership Mutex

This block carries single bytes between a console agent and a processor agent. A two-bit ownership field serves as a mutex, and only the holder of that mutex may place a byte into the shared data register. The side that does not hold the mutex receives the byte. It sees a data-ready flag, reads the byte, and that read frees the register for the next byte. The sender can end a transfer by sending its last byte with a data-end flag. That byte also gives up ownership, so the other side can take the mutex and reply.

The processor may try to grab the mutex only at an instruction-retire point, and the grab succeeds only when the field reads unowned. The console may grab at any cycle. The console also has a direct write port to the ownership field, so a host can force or clear ownership. An illegal value written there is turned into "no owner". Each side sees a four-bit control view: bit 0 says the mutex is held by someone, bit 1 says this side may send, bit 2 says a byte is waiting for this side, and bit 3 says that waiting byte ended the transfer.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset the ownership field is 00 and both four-bit control views are 0000.
- R2: Ownership codes are 00 none, 01 console, 10 processor. Control bit 0 is 1 exactly when the field is not 00. Control bit 1 is 1 for the owning side while no byte is waiting.
- R3: A processor grab with retire high and the field at 00 sets the field to 10 one cycle later. A processor grab without retire leaves it unchanged.
- R4: When both sides grab in the same cycle (processor with retire high) and the field is 00, the field becomes 01.
- R5: A grab by either side while the field is not 00 leaves the field unchanged.
- R6: A send by the owner while no byte is waiting loads the byte. The next cycle sets bit 2 in the receiver's view and clears bit 1 in the owner's view. A send by the non-owner changes nothing.
- R7: A send while a byte is still waiting is ignored: the data output keeps the earlier byte.
- R8: A read by the receiving side while a byte waits clears bits 2 and 3 in its view. A read by the side that sent the byte has no effect.
- R9: A release by the owner returns the field to 00. A release by the non-owner is ignored.
- R10: An accepted send with the end flag loads the byte, sets bits 2 and 3 in the receiver's view, and returns the field to 00, all in the same cycle.
- R11: The console ownership write stores 00, 01 or 10 as given and stores 00 when given 11. It takes priority over grabs and releases in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| con_grab_i | input | 1 | Console requests the mutex |
| con_rel_i | input | 1 | Console releases the mutex |
| con_send_i | input | 1 | Console sends con_wdata_i |
| con_end_i | input | 1 | Marks the console send as the last byte |
| con_wdata_i | input | DATA_W | Console byte to send |
| con_rd_i | input | 1 | Console reads the waiting byte |
| con_own_we_i | input | 1 | Console writes the ownership field |
| con_own_i | input | 2 | Value for the ownership write |
| con_rdata_o | output | DATA_W | Shared data register seen by the console |
| con_ctrl_o | output | 4 | Console control view |
| cpu_retire_i | input | 1 | Processor is at an instruction-retire point |
| cpu_grab_i | input | 1 | Processor requests the mutex |
| cpu_rel_i | input | 1 | Processor releases the mutex |
| cpu_send_i | input | 1 | Processor sends cpu_wdata_i |
| cpu_end_i | input | 1 | Marks the processor send as the last byte |
| cpu_wdata_i | input | DATA_W | Processor byte to send |
| cpu_rd_i | input | 1 | Processor reads the waiting byte |
| cpu_rdata_o | output | DATA_W | Shared data register seen by the processor |
| cpu_ctrl_o | output | 4 | Processor control view |
| own_o | output | 2 | Ownership field |

## Verification
The bench targets the following corner cases:
- **Same-cycle grabs.** Both sides grab in one cycle. A wrong priority would hand the mutex to the processor or produce code 11.
- **Grab without retire.** The processor grabs off a retire point. A design that ignores the retire gate would take ownership mid-instruction.
- **Send or read by the wrong side.** A send while a byte is still waiting, or a read by the sender, must change nothing. Getting this wrong would overwrite an unread byte or drop data-ready before the receiver saw it.
- **End flag and illegal write.** A send with the end flag must free the mutex in the same cycle as the byte, and an ownership write of 11 must leave the field at 00. A wrong design would leave the mutex held and deadlock the reply, or hold an encoding no side recognises.

Random traffic is then compared cycle by cycle against a reference model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'b00,
      OWN_CON  = 2'b01,
      OWN_CPU  = 2'b10,
      OWN_BAD  = 2'b11
   } own_e;

   localparam int NSIDE     = 2;
   localparam int SIDE_CON  = 0;
   localparam int SIDE_CPU  = 1;
   localparam int CB_MUTEX  = 0;
   localparam int CB_SREADY = 1;
   localparam int CB_DREADY = 2;
   localparam int CB_DEND   = 3;
   localparam int CTRL_W    = 4;
endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter
   import mbx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSIDE-1:0] grab_i,
   input  logic             retire_i,
   input  logic [NSIDE-1:0] rel_i,
   input  logic             end_acc_i,
   input  logic             we_i,
   input  logic [1:0]       wval_i,
   output logic [1:0]       own_o
);
   logic [1:0] own_q, own_d;
   logic       con_holds, cpu_holds, cpu_try;

   assign con_holds = (own_q == OWN_CON);
   assign cpu_holds = (own_q == OWN_CPU);
   assign cpu_try   = grab_i[SIDE_CPU] & retire_i;

   always_comb begin
      own_d = own_q;
      if (we_i) begin
         own_d = (wval_i == OWN_BAD) ? OWN_NONE : wval_i;
      end else if (end_acc_i) begin
         own_d = OWN_NONE;
      end else if ((con_holds & rel_i[SIDE_CON]) | (cpu_holds & rel_i[SIDE_CPU])) begin
         own_d = OWN_NONE;
      end else if (own_q == OWN_NONE) begin
         if (grab_i[SIDE_CON])  own_d = OWN_CON;
         else if (cpu_try)      own_d = OWN_CPU;
      end else if (own_q == OWN_BAD) begin
         own_d = OWN_NONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) own_q <= OWN_NONE;
      else        own_q <= own_d;
   end

   assign own_o = own_q;

   p_grab_tie_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && grab_i[SIDE_CON] && cpu_try && !we_i && !end_acc_i)
      |=> (own_o == OWN_CON));

   p_retire_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && !retire_i && !grab_i[SIDE_CON] && !we_i)
      |=> (own_o == OWN_NONE));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q != OWN_NONE && !we_i && !end_acc_i && rel_i == '0)
      |=> $stable(own_o));

   p_illegal_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && wval_i == OWN_BAD) |=> (own_o == OWN_NONE));

   p_end_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (end_acc_i && !we_i) |=> (own_o == OWN_NONE));
endmodule

// File: rtl/mbx_databuf.sv
module mbx_databuf
   import mbx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NSIDE-1:0]             owns_i,
   input  logic [NSIDE-1:0]             send_i,
   input  logic [NSIDE-1:0]             end_i,
   input  logic [NSIDE-1:0][DATA_W-1:0] wdata_i,
   input  logic [NSIDE-1:0]             rd_i,
   output logic [DATA_W-1:0]            data_o,
   output logic                         dready_o,
   output logic                         dend_o,
   output logic                         sender_o,
   output logic                         end_acc_o
);
   logic [DATA_W-1:0] data_q;
   logic              dr_q, de_q, snd_q;
   logic [NSIDE-1:0]  acc;
   logic              rd_acc, any_acc, acc_side;

   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_acc
         assign acc[s] = owns_i[s] & send_i[s] & ~dr_q;
      end
   endgenerate

   assign any_acc   = |acc;
   assign acc_side  = acc[SIDE_CPU];
   assign end_acc_o = |(acc & end_i);
   assign rd_acc    = dr_q & (snd_q ? rd_i[SIDE_CON] : rd_i[SIDE_CPU]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         dr_q   <= 1'b0;
         de_q   <= 1'b0;
         snd_q  <= 1'b0;
      end else if (any_acc) begin
         data_q <= wdata_i[acc_side];
         dr_q   <= 1'b1;
         de_q   <= end_i[acc_side];
         snd_q  <= acc_side;
      end else if (rd_acc) begin
         dr_q   <= 1'b0;
         de_q   <= 1'b0;
      end
   end

   assign data_o   = data_q;
   assign dready_o = dr_q;
   assign dend_o   = de_q;
   assign sender_o = snd_q;

   p_no_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_q && !rd_acc) |=> ($stable(data_o) && dready_o));

   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> (!dready_o && !dend_o));

   p_single_sender_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(acc));
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
   import mbx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              con_grab_i,
   input  logic              con_rel_i,
   input  logic              con_send_i,
   input  logic              con_end_i,
   input  logic [DATA_W-1:0] con_wdata_i,
   input  logic              con_rd_i,
   input  logic              con_own_we_i,
   input  logic [1:0]        con_own_i,
   output logic [DATA_W-1:0] con_rdata_o,
   output logic [3:0]        con_ctrl_o,
   input  logic              cpu_retire_i,
   input  logic              cpu_grab_i,
   input  logic              cpu_rel_i,
   input  logic              cpu_send_i,
   input  logic              cpu_end_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   input  logic              cpu_rd_i,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic [3:0]        cpu_ctrl_o,
   output logic [1:0]        own_o
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mbx_mailbox: DATA_W must be at least 1");
      end
   endgenerate

   logic [1:0]                   own;
   logic [NSIDE-1:0]             owns, grab, rel, send, endf, rd;
   logic [NSIDE-1:0][DATA_W-1:0] wdata;
   logic [NSIDE-1:0][CTRL_W-1:0] ctrl;
   logic [DATA_W-1:0]            data;
   logic                         dready, dend, sender, end_acc;

   assign grab  = {cpu_grab_i,  con_grab_i};
   assign rel   = {cpu_rel_i,   con_rel_i};
   assign send  = {cpu_send_i,  con_send_i};
   assign endf  = {cpu_end_i,   con_end_i};
   assign rd    = {cpu_rd_i,    con_rd_i};
   assign wdata = {cpu_wdata_i, con_wdata_i};

   mbx_arbiter u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .grab_i    (grab),
      .retire_i  (cpu_retire_i),
      .rel_i     (rel),
      .end_acc_i (end_acc),
      .we_i      (con_own_we_i),
      .wval_i    (con_own_i),
      .own_o     (own)
   );

   mbx_databuf #(.DATA_W(DATA_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .owns_i    (owns),
      .send_i    (send),
      .end_i     (endf),
      .wdata_i   (wdata),
      .rd_i      (rd),
      .data_o    (data),
      .dready_o  (dready),
      .dend_o    (dend),
      .sender_o  (sender),
      .end_acc_o (end_acc)
   );

   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_side
         localparam logic [1:0] MY_CODE = (s == SIDE_CON) ? OWN_CON : OWN_CPU;
         logic receiver;
         assign owns[s]   = (own == MY_CODE);
         assign receiver  = (sender != s[0]);
         assign ctrl[s][CB_MUTEX]  = (own != OWN_NONE);
         assign ctrl[s][CB_SREADY] = owns[s] & ~dready;
         assign ctrl[s][CB_DREADY] = dready & receiver;
         assign ctrl[s][CB_DEND]   = dend & receiver;
      end
   endgenerate

   assign con_ctrl_o  = ctrl[SIDE_CON];
   assign cpu_ctrl_o  = ctrl[SIDE_CPU];
   assign con_rdata_o = data;
   assign cpu_rdata_o = data;
   assign own_o       = own;

   p_mutex_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (con_ctrl_o[CB_MUTEX] == cpu_ctrl_o[CB_MUTEX]) && !(con_ctrl_o[CB_SREADY] && cpu_ctrl_o[CB_SREADY]));

   p_one_waiter_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({con_ctrl_o[CB_DREADY], cpu_ctrl_o[CB_DREADY]}) <= 1);
endmodule

// File: tb/sim_mbx_mailbox.sv
module sim_mbx_mailbox;
   localparam int DW = 8;

   logic clk = 0, rst_n = 0;
   logic con_grab_i = 0, con_rel_i = 0, con_send_i = 0, con_end_i = 0, con_rd_i = 0, con_own_we_i = 0;
   logic [DW-1:0] con_wdata_i = 0, cpu_wdata_i = 0;
   logic [1:0] con_own_i = 0;
   logic cpu_retire_i = 0, cpu_grab_i = 0, cpu_rel_i = 0, cpu_send_i = 0, cpu_end_i = 0, cpu_rd_i = 0;
   logic [DW-1:0] con_rdata_o, cpu_rdata_o;
   logic [3:0] con_ctrl_o, cpu_ctrl_o;
   logic [1:0] own_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [1:0] m_own = 0;
   logic m_dr = 0, m_de = 0, m_snd = 0;
   logic [DW-1:0] m_data = 0;

   always #5 clk = ~clk;

   mbx_mailbox #(.DATA_W(DW)) u0 (.*);

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic [3:0] exp_ctrl(input int s);
      logic mine = (s == 0) ? (m_own == 2'b01) : (m_own == 2'b10);
      logic recv = (m_snd != s[0]);
      return {m_de & recv, m_dr & recv, mine & ~m_dr, m_own != 2'b00};
   endfunction

   task automatic model_step();
      logic a0 = (m_own == 2'b01) && con_send_i && !m_dr;
      logic a1 = (m_own == 2'b10) && cpu_send_i && !m_dr;
      logic ra = m_dr && (m_snd ? con_rd_i : cpu_rd_i);
      logic [1:0] o = m_own;
      if (con_own_we_i) o = (con_own_i == 2'b11) ? 2'b00 : con_own_i;
      else if ((a0 && con_end_i) || (a1 && cpu_end_i)) o = 2'b00;
      else if ((m_own == 2'b01 && con_rel_i) || (m_own == 2'b10 && cpu_rel_i)) o = 2'b00;
      else if (m_own == 2'b00) begin
         if (con_grab_i) o = 2'b01;
         else if (cpu_grab_i && cpu_retire_i) o = 2'b10;
      end
      if (a0 || a1) begin
         m_data = a1 ? cpu_wdata_i : con_wdata_i;
         m_dr = 1; m_de = a1 ? cpu_end_i : con_end_i; m_snd = a1;
      end else if (ra) begin
         m_dr = 0; m_de = 0;
      end
      m_own = o;
   endtask

   task automatic idle();
      {con_grab_i, con_rel_i, con_send_i, con_end_i, con_rd_i, con_own_we_i} = '0;
      {cpu_retire_i, cpu_grab_i, cpu_rel_i, cpu_send_i, cpu_end_i, cpu_rd_i} = '0;
   endtask

   task automatic cyc();
      @(posedge clk);
      if (rst_n) model_step();
      @(negedge clk);
      idle();
   endtask

   initial begin
      idle();
      @(negedge clk); cyc(); cyc();
      rst_n = 1;
      chk("R1 own", own_o, 2'b00);
      chk("R1 con_ctrl", con_ctrl_o, 4'b0000);
      chk("R1 cpu_ctrl", cpu_ctrl_o, 4'b0000);
      cpu_grab_i = 1; cyc();
      chk("R3 no retire", own_o, 2'b00);
      con_grab_i = 1; cpu_grab_i = 1; cpu_retire_i = 1; cyc();
      chk("R4 tie", own_o, 2'b01);
      chk("R2 con view", con_ctrl_o, 4'b0011);
      chk("R2 cpu view", cpu_ctrl_o, 4'b0001);
      cpu_grab_i = 1; cpu_retire_i = 1; cyc();
      chk("R5 held", own_o, 2'b01);
      cpu_send_i = 1; cpu_wdata_i = 8'h55; cyc();
      chk("R6 nonowner send", cpu_ctrl_o, 4'b0001);
      chk("R6 nonowner send con", con_ctrl_o, 4'b0011);
      con_send_i = 1; con_wdata_i = 8'hA5; cyc();
      chk("R6 cpu dready", cpu_ctrl_o, 4'b0101);
      chk("R6 con sready off", con_ctrl_o, 4'b0001);
      chk("R6 data", cpu_rdata_o, 8'hA5);
      con_send_i = 1; con_wdata_i = 8'h3C; cyc();
      chk("R7 no overwrite", con_rdata_o, 8'hA5);
      con_rd_i = 1; cyc();
      chk("R8 sender read", cpu_ctrl_o, 4'b0101);
      cpu_rd_i = 1; cyc();
      chk("R8 receiver read", cpu_ctrl_o, 4'b0001);
      cpu_rel_i = 1; cyc();
      chk("R9 nonowner release", own_o, 2'b01);
      con_rel_i = 1; cyc();
      chk("R9 owner release", own_o, 2'b00);
      cpu_grab_i = 1; cpu_retire_i = 1; cyc();
      chk("R3 retire grab", own_o, 2'b10);
      cpu_send_i = 1; cpu_end_i = 1; cpu_wdata_i = 8'h7E; cyc();
      chk("R10 own freed", own_o, 2'b00);
      chk("R10 con view", con_ctrl_o, 4'b1100);
      chk("R10 data", con_rdata_o, 8'h7E);
      con_rd_i = 1; cyc();
      chk("R8 end cleared", con_ctrl_o, 4'b0000);
      con_own_we_i = 1; con_own_i = 2'b11; cyc();
      chk("R11 illegal", own_o, 2'b00);
      con_own_we_i = 1; con_own_i = 2'b10; con_grab_i = 1; cyc();
      chk("R11 write wins", own_o, 2'b10);
      con_own_we_i = 1; con_own_i = 2'b00; cyc();
      chk("R11 clear", own_o, 2'b00);
      for (int i = 0; i < 4000; i++) begin
         con_grab_i   = ($urandom % 6) == 0;
         con_rel_i    = ($urandom % 10) == 0;
         con_send_i   = ($urandom % 3) == 0;
         con_end_i    = ($urandom % 4) == 0;
         con_rd_i     = ($urandom % 3) == 0;
         con_wdata_i  = DW'($urandom);
         con_own_we_i = ($urandom % 40) == 0;
         con_own_i    = 2'($urandom);
         cpu_retire_i = ($urandom % 2) == 0;
         cpu_grab_i   = ($urandom % 4) == 0;
         cpu_rel_i    = ($urandom % 10) == 0;
         cpu_send_i   = ($urandom % 3) == 0;
         cpu_end_i    = ($urandom % 4) == 0;
         cpu_rd_i     = ($urandom % 3) == 0;
         cpu_wdata_i  = DW'($urandom);
         cyc();
         chk("RND own R2", own_o, m_own);
         chk("RND con ctrl R6", con_ctrl_o, exp_ctrl(0));
         chk("RND cpu ctrl R8", cpu_ctrl_o, exp_ctrl(1));
         chk("RND data R7", con_rdata_o, m_data);
      end
      done = 1;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int t = 0; t < 100000 && !done; t++) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog got=hung exp=done");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule